// File: doc/BRIEF.md
# Oversampled ADC Result Readout Register

This block sits between the output of a sinc3 decimation filter for one ADC channel and a processor read bus. When the filter reports a new sample, the block captures it into a holding register and sets a buffer-full flag. The captured result is then presented as two readable items: a 16-bit upper word and an 8-bit low byte. How many result bits exist depends on the oversampling ratio. The result is stored left-aligned, so the upper word always carries the sixteen most significant bits. Any extra resolution goes into the top of the low byte, and the byte's unused positions read as zero.

Software reads the low byte first and then the upper word. The upper-word read clears the buffer-full flag, but only if no bus write happens in the same cycle. A read of the low byte leaves the flag untouched, so the flag going low means the whole result was taken. When the channel is switched off, the block ignores new samples. It then returns the last captured data while the flag is still set, and all ones once the flag is clear.

Top module: `adc_result_port`

## Requirements
- R1: After reset the flag is 0. With the channel enabled, an upper-word read returns FFFFh and a low-byte read returns 00FFh.
- R2: A sample strobe with the channel enabled captures the 24-bit filter output and sets the flag in the following cycle.
- R3: The oversampling code `osr_sel` selects the result width: 0 gives 16 bits, 1 gives 19, 2 gives 22 and 3 gives 24. The result sits in the low bits of `smp_data`. An upper-word read returns the result's top 16 bits.
- R4: Let e be the result width minus 16. A low-byte read returns the result's lowest e bits in byte bits 7 down to 8-e, with zeros below them and zeros in `rd_data[15:8]`. For code 0 the byte is all zeros.
- R5: A change of `osr_sel` changes nothing readable until the next captured sample.
- R6: An upper-word read (`rd_sel`=0) with `wr_en` low clears the flag in the following cycle.
- R7: An upper-word read in a cycle with `wr_en` high leaves the flag set.
- R8: A low-byte read (`rd_sel`=1) leaves the flag unchanged.
- R9: If a strobe and a clearing read fall in the same cycle, the read returns the previous data and the flag stays set.
- R10: With the channel disabled and the flag set, reads return the last captured data.
- R11: With the channel disabled and the flag clear, an upper-word read returns FFFFh and a low-byte read returns 00FFh.
- R12: Strobes are ignored while the channel is disabled: the flag and the held data do not change.
- R13: With `rd_en` low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_en | input | 1 | Channel enable |
| osr_sel | input | 2 | Oversampling ratio code (0..3 for 32..256) |
| smp_valid | input | 1 | New-sample strobe from the filter |
| smp_data | input | 24 | Filter output, right-aligned |
| rd_en | input | 1 | Read access this cycle |
| rd_sel | input | 1 | 0 selects the upper word, 1 selects the low byte |
| wr_en | input | 1 | A bus write occurs this cycle |
| rd_data | output | 16 | Read data, valid in the same cycle as rd_en |
| full_flag | output | 1 | Buffer-full flag |

## Verification
The assertions check the following on every cycle:
- the flag's response to captures, clearing reads and write-blocked reads;
- the all-ones return of a disabled, empty channel;
- that the held data is frozen while the channel is off;
- that the zero padding in the low byte matches the captured ratio;
- that the bus is idle without a read.

Only the bench's scenarios can show the actual bit placement of the upper word and low byte. The bench sweeps every ratio over walking-one and pseudo-random samples to do this. The scenarios also cover the delayed effect of a ratio change, the ordering of a strobe against a same-cycle read, and the sequence of a disabled channel returning stale data and then all ones.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int DATA_W = 24;
  localparam int WORD_W = 16;
  localparam int BYTE_W = DATA_W - WORD_W;
  localparam int OSR_W  = 2;

  typedef enum logic [OSR_W-1:0] {
    OSR_32  = 2'd0,
    OSR_64  = 2'd1,
    OSR_128 = 2'd2,
    OSR_256 = 2'd3
  } osr_e;

  typedef enum logic {
    SEL_WORD = 1'b0,
    SEL_BYTE = 1'b1
  } rsel_e;

  // number of meaningful result bits for a ratio code
  function automatic int unsigned res_width(logic [OSR_W-1:0] osr);
    case (osr)
      OSR_32:  return 16;
      OSR_64:  return 19;
      OSR_128: return 22;
      default: return 24;
    endcase
  endfunction

  // left-justify a right-aligned filter result inside DATA_W bits
  function automatic logic [DATA_W-1:0] align_result(logic [DATA_W-1:0] raw,
                                                     logic [OSR_W-1:0]  osr);
    logic [4:0] shamt;
    shamt = 5'(DATA_W - int'(res_width(osr)));
    return raw << shamt;
  endfunction

endpackage

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [DW-1:0]    raw,
  input  logic [OSR_W-1:0] osr,
  output logic [DW-1:0]    hold_q,
  output logic [OSR_W-1:0] osr_q
);

  logic [DW-1:0] aligned;

  always_comb aligned = align_result(raw, osr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '1;
      osr_q  <= OSR_256;
    end else if (cap_evt) begin
      hold_q <= aligned;
      osr_q  <= osr;
    end
  end

endmodule

// File: rtl/adc_rd_flag.sv
module adc_rd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_evt,
  input  logic clr_evt,
  output logic full_q
);

  logic full_d;

  // a capture wins over a clearing read in the same cycle
  always_comb begin
    full_d = full_q;
    if (cap_evt)      full_d = 1'b1;
    else if (clr_evt) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

endmodule

// File: rtl/adc_rd_mux.sv
module adc_rd_mux
  import adc_rd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int WW = WORD_W
) (
  input  logic          rd_en,
  input  logic          rd_sel,
  input  logic          chan_en,
  input  logic          full,
  input  logic [DW-1:0] hold,
  output logic [WW-1:0] rd_data
);

  localparam int BW = DW - WW;

  logic [WW-1:0] word_v;
  logic [WW-1:0] byte_v;
  logic          blank;

  always_comb begin
    word_v = hold[DW-1 -: WW];
    byte_v = {{(WW-BW){1'b0}}, hold[BW-1:0]};
    blank  = !chan_en && !full;
  end

  always_comb begin
    if (!rd_en)
      rd_data = '0;
    else if (blank)
      rd_data = (rd_sel == SEL_WORD) ? {WW{1'b1}} : {{(WW-BW){1'b0}}, {BW{1'b1}}};
    else
      rd_data = (rd_sel == SEL_WORD) ? word_v : byte_v;
  end

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_rd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int WW = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic [OSR_W-1:0] osr_sel,
  input  logic             smp_valid,
  input  logic [DW-1:0]    smp_data,
  input  logic             rd_en,
  input  logic             rd_sel,
  input  logic             wr_en,
  output logic [WW-1:0]    rd_data,
  output logic             full_flag
);

  // named internal events
  logic             cap_evt;
  logic             clr_evt;
  logic [DW-1:0]    hold_q;
  logic [OSR_W-1:0] osr_q;

  assign cap_evt = smp_valid && chan_en;
  assign clr_evt = rd_en && (rd_sel == SEL_WORD) && !wr_en;

  adc_rd_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_evt(cap_evt),
    .raw    (smp_data),
    .osr    (osr_sel),
    .hold_q (hold_q),
    .osr_q  (osr_q)
  );

  adc_rd_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_evt(cap_evt),
    .clr_evt(clr_evt),
    .full_q (full_flag)
  );

  adc_rd_mux #(.DW(DW), .WW(WW)) u_mux (
    .rd_en  (rd_en),
    .rd_sel (rd_sel),
    .chan_en(chan_en),
    .full   (full_flag),
    .hold   (hold_q),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk
  import adc_rd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int WW = WORD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             rd_en,
  input logic             rd_sel,
  input logic             wr_en,
  input logic [WW-1:0]    rd_data,
  input logic             full_flag,
  input logic             cap_evt,
  input logic             clr_evt,
  input logic [DW-1:0]    hold_q,
  input logic [OSR_W-1:0] osr_q
);

  // R2
  capture_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> full_flag);

  // R6
  word_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !cap_evt) |=> !full_flag);

  // R7
  write_blocks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && rd_en && rd_sel == SEL_WORD && wr_en) |=> full_flag);

  // R8
  byte_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && rd_en && rd_sel == SEL_BYTE) |=> full_flag);

  // R11
  empty_off_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !full_flag && rd_en && rd_sel == SEL_WORD) |-> rd_data == {WW{1'b1}});

  // R12
  off_hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (hold_q == $past(hold_q)));

  // R4
  byte_pad_osr32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osr_q == OSR_32) |-> (hold_q[DW-WW-1:0] == '0));

  // R4
  byte_pad_osr64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osr_q == OSR_64) |-> (hold_q[4:0] == '0));

  // R13
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

endmodule

bind adc_result_port adc_result_port_chk #(.DW(DW), .WW(WW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .rd_en    (rd_en),
  .rd_sel   (rd_sel),
  .wr_en    (wr_en),
  .rd_data  (rd_data),
  .full_flag(full_flag),
  .cap_evt  (cap_evt),
  .clr_evt  (clr_evt),
  .hold_q   (hold_q),
  .osr_q    (osr_q)
);

// File: tb/adc_result_port_bench.sv
module adc_result_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b1;
  logic [1:0]  osr_sel = 2'd0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] rd_data;
  logic        full_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_result_port u_adc_result_port (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .osr_sel(osr_sel),
    .smp_valid(smp_valid), .smp_data(smp_data), .rd_en(rd_en),
    .rd_sel(rd_sel), .wr_en(wr_en), .rd_data(rd_data), .full_flag(full_flag)
  );

  // expected values, derived from the width table of R3/R4
  function automatic int extra_bits(input logic [1:0] osr);
    case (osr)
      2'd0: return 0;
      2'd1: return 3;
      2'd2: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(input logic [23:0] raw, input logic [1:0] osr);
    logic [31:0] v;
    v = {8'h00, raw} >> extra_bits(osr);
    return v[15:0];
  endfunction

  function automatic logic [15:0] exp_byte(input logic [23:0] raw, input logic [1:0] osr);
    int e;
    logic [31:0] v;
    e = extra_bits(osr);
    if (e == 0) return 16'h0000;
    v = ({8'h00, raw} & ((32'd1 << e) - 32'd1)) << (8 - e);
    return {8'h00, v[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic strobe(input logic [23:0] d);
    smp_valid = 1'b1;
    smp_data  = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic bus_read(input logic sel, input logic wr, output logic [15:0] d);
    rd_en  = 1'b1;
    rd_sel = sel;
    wr_en  = wr;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] d;
    logic [23:0] lfsr;
    logic [23:0] a;
    logic [23:0] b;
    lfsr = 24'hACE1B5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flag", full_flag, 0);
    bus_read(0, 0, d); check("R1 word", d, 16'hFFFF);
    bus_read(1, 0, d); check("R1 byte", d, 16'h00FF);
    #1 check("R13 idle bus", rd_data, 0);

    // R2 R3 R4 R6 R8 sweep over every ratio
    for (int o = 0; o < 4; o++) begin
      osr_sel = 2'(o);
      for (int k = 0; k < 40; k++) begin
        if (k < 24) a = 24'd1 << k;
        else begin
          lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
          a = lfsr;
        end
        strobe(a);
        check("R2 flag set", full_flag, 1);
        bus_read(1, 0, d); check("R4 byte", d, exp_byte(a, 2'(o)));
        check("R8 flag kept", full_flag, 1);
        bus_read(0, 0, d); check("R3 word", d, exp_word(a, 2'(o)));
        check("R6 flag cleared", full_flag, 0);
      end
    end

    // R5 ratio change waits for a capture
    a = 24'h5A3C96; b = 24'hC3E71F;
    osr_sel = 2'd0; strobe(a);
    osr_sel = 2'd3; @(negedge clk);
    bus_read(1, 0, d); check("R5 byte old ratio", d, exp_byte(a, 2'd0));
    bus_read(0, 0, d); check("R5 word old ratio", d, exp_word(a, 2'd0));
    strobe(b);
    bus_read(1, 0, d); check("R5 byte new ratio", d, exp_byte(b, 2'd3));
    bus_read(0, 0, d); check("R5 word new ratio", d, exp_word(b, 2'd3));

    // R7 write in the same cycle blocks the clear
    osr_sel = 2'd2; strobe(a);
    bus_read(0, 1, d); check("R7 word", d, exp_word(a, 2'd2));
    check("R7 flag kept", full_flag, 1);
    bus_read(0, 0, d); check("R7 then clear", full_flag, 0);

    // R9 strobe and clearing read together
    strobe(a);
    smp_valid = 1'b1; smp_data = b;
    rd_en = 1'b1; rd_sel = 1'b0; wr_en = 1'b0;
    #1 d = rd_data;
    @(negedge clk);
    smp_valid = 1'b0; rd_en = 1'b0;
    check("R9 old data", d, exp_word(a, 2'd2));
    check("R9 flag stays", full_flag, 1);
    bus_read(0, 0, d); check("R9 new data", d, exp_word(b, 2'd2));

    // R10 disabled channel with flag set
    osr_sel = 2'd1; strobe(a);
    chan_en = 1'b0; @(negedge clk);
    bus_read(1, 0, d); check("R10 byte", d, exp_byte(a, 2'd1));
    bus_read(0, 0, d); check("R10 word", d, exp_word(a, 2'd1));
    // R11 now the flag is clear
    check("R11 flag", full_flag, 0);
    bus_read(0, 0, d); check("R11 word", d, 16'hFFFF);
    bus_read(1, 0, d); check("R11 byte", d, 16'h00FF);

    // R12 strobes ignored while disabled
    osr_sel = 2'd3; strobe(b);
    check("R12 flag", full_flag, 0);
    bus_read(0, 0, d); check("R12 word", d, 16'hFFFF);
    chan_en = 1'b1; @(negedge clk);
    bus_read(0, 0, d); check("R12 held word", d, exp_word(a, 2'd1));
    bus_read(1, 0, d); check("R12 held byte", d, exp_byte(a, 2'd1));
    #1 check("R13 idle bus end", rd_data, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule